// File: doc/BRIEF.md
# Linked-List DMA Descriptor Sequencer

This block runs one DMA channel through a chain of descriptors kept in memory. When software turns on chaining while the channel is idle, the sequencer reads the descriptor that the channel's next-pointer register points at. A descriptor is a next-pointer word, then a config word, then only those optional register words that the config word flags. Flagged words overwrite the matching channel registers. All other channel registers keep their values. When the load is done, the sequencer commits the new next pointer and the descriptor's enable and chaining bits. It then waits for a rising edge on the trigger input.

A trigger edge while the channel is enabled starts a cell on the address generator through a one-cycle `cell_go` pulse. The generator answers with `cell_done`. With cell auto-start on, cells follow each other back to back until the bytes moved reach the block size. With cell auto-start off, each cell needs its own trigger edge. When the block completes, hardware clears the enable. The sequencer then fetches the next descriptor if chaining is still on, and goes idle if it is not. A circular chain therefore repeats until software turns chaining off.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, `ch_en`, `ch_llen`, `ch_cast`, `mem_req` and `cell_go` are 0.
- R2: Software writes use `sw_sel` 0 for next pointer, 1 for source start, 2 for destination start, 3 for block size in bytes, 4 for cell size in bytes, and 5 for control (bit 0 chaining enable, bit 1 cell auto-start). A control write with bit 0 set while idle raises `mem_req` on the next cycle, with `mem_addr` equal to the next-pointer register.
- R3: A descriptor at address A has its next pointer at A, its config word at A+4, and its optional words from A+8 upward, in this order: source start (config bit 0), destination start (bit 1), block size (bit 2), cell size (bit 3). Exactly 2 plus the number of set flags words are read. Only flagged registers change.
- R4: When the load ends, `ch_nxt` takes the fetched pointer, and `ch_en` and `ch_llen` take config bits 8 and 9. `ch_en` stays 0 while any descriptor word is being fetched.
- R5: A rising trigger edge while `ch_en` is 1 and no cell is in flight gives exactly one `cell_go` pulse. A trigger held high counts once.
- R6: Trigger edges while `ch_en` is 0, including during a descriptor load, are dropped and not remembered.
- R7: With auto-start on, each `cell_done` that leaves the block unfinished is followed by another `cell_go` with no further trigger. With auto-start off, each cell waits for a new trigger edge.
- R8: The block ends at the `cell_done` that brings the bytes moved to the block size or beyond. `ch_en` clears on the next cycle. If `ch_llen` is 1, the fetch from `ch_nxt` starts in that same cycle, so a circular chain loops.
- R9: If `ch_llen` is 0 when the block ends, the sequencer goes idle and does not fetch. Clearing it in the middle of a block lets that block finish.
- R10: A descriptor whose config bit 8 is 0 leaves `ch_en` at 0 after loading, and the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr | input | 1 | Software register write strobe |
| sw_sel | input | 3 | Register selector for the write |
| sw_wdata | input | W | Write data |
| trig | input | 1 | Start trigger, edge detected |
| mem_req | output | 1 | Descriptor read request, held until data returns |
| mem_addr | output | W | Descriptor word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | W | Read data |
| cell_go | output | 1 | One-cycle cell start to the address generator |
| cell_done | input | 1 | Cell finished |
| ch_en | output | 1 | Channel enable (armed) |
| ch_llen | output | 1 | Chaining enable |
| ch_cast | output | 1 | Cell auto-start enable |
| ch_nxt | output | W | Next descriptor pointer |
| ch_ssa | output | W | Source start address |
| ch_dsa | output | W | Destination start address |
| ch_blksz | output | W | Block size in bytes |
| ch_csz | output | W | Cell size in bytes |

## Verification
The hardest case to reach is a trigger edge during a descriptor load. The load lasts only a few cycles, and from the ports it looks the same as a trigger that came too early. The bench starts a fetch and fires a one-cycle trigger while `mem_req` is still high. After the channel arms, it waits and confirms that no cell started. A second hard case is a trigger held high across a whole cell with auto-start off. The bench switches auto-start off while the channel is armed, which starts no fetch, and keeps the trigger high for many cycles.

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_wr,
  input  logic [2:0]   sw_sel,
  input  logic [W-1:0] sw_wdata,
  input  logic         trig,
  output logic         mem_req,
  output logic [W-1:0] mem_addr,
  input  logic         mem_rvalid,
  input  logic [W-1:0] mem_rdata,
  output logic         cell_go,
  input  logic         cell_done,
  output logic         ch_en,
  output logic         ch_llen,
  output logic         ch_cast,
  output logic [W-1:0] ch_nxt,
  output logic [W-1:0] ch_ssa,
  output logic [W-1:0] ch_dsa,
  output logic [W-1:0] ch_blksz,
  output logic [W-1:0] ch_csz
);
  localparam int STEP   = W / 8;
  localparam int NOPT   = 4;
  localparam int EN_BIT = 8;
  localparam int LL_BIT = 9;
  localparam logic [2:0] SEL_CTRL = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_NXT, S_CFG, S_OPT, S_ARM, S_XFER} st_t;
  st_t st;

  logic [W-1:0]    fa, nxt_tmp, xcnt;
  logic [NOPT-1:0] pend;
  logic            d_en, d_ll, trig_q;

  wire             trig_edge = trig & ~trig_q;
  wire [NOPT-1:0]  pick      = pend & (~pend + 1'b1);
  wire [NOPT-1:0]  pend_nx   = pend & (pend - 1'b1);
  wire [W-1:0]     xsum      = xcnt + ch_csz;
  wire             last      = xsum >= ch_blksz;
  wire             cfg_done  = st == S_CFG && mem_rvalid && mem_rdata[NOPT-1:0] == '0;
  wire             opt_done  = st == S_OPT && mem_rvalid && pend_nx == '0;
  wire             commit    = cfg_done | opt_done;
  wire             c_en      = cfg_done ? mem_rdata[EN_BIT] : d_en;
  wire             c_ll      = cfg_done ? mem_rdata[LL_BIT] : d_ll;

  assign mem_req  = st == S_NXT || st == S_CFG || st == S_OPT;
  assign mem_addr = fa;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      fa <= '0;
      nxt_tmp <= '0;
      xcnt <= '0;
      pend <= '0;
      d_en <= 1'b0;
      d_ll <= 1'b0;
      trig_q <= 1'b0;
      cell_go <= 1'b0;
      ch_en <= 1'b0;
      ch_llen <= 1'b0;
      ch_cast <= 1'b0;
      ch_nxt <= '0;
      ch_ssa <= '0;
      ch_dsa <= '0;
      ch_blksz <= '0;
      ch_csz <= '0;
    end else begin
      trig_q  <= trig;
      cell_go <= 1'b0;

      if (sw_wr) begin
        case (sw_sel)
          3'd0: ch_nxt   <= sw_wdata;
          3'd1: ch_ssa   <= sw_wdata;
          3'd2: ch_dsa   <= sw_wdata;
          3'd3: ch_blksz <= sw_wdata;
          3'd4: ch_csz   <= sw_wdata;
          SEL_CTRL: begin
            ch_llen <= sw_wdata[0];
            ch_cast <= sw_wdata[1];
          end
          default: ;
        endcase
      end

      case (st)
        S_IDLE:
          if (sw_wr && sw_sel == SEL_CTRL && sw_wdata[0]) begin
            fa <= ch_nxt;
            st <= S_NXT;
          end
        S_NXT:
          if (mem_rvalid) begin
            nxt_tmp <= mem_rdata;
            fa <= fa + STEP;
            st <= S_CFG;
          end
        S_CFG:
          if (mem_rvalid) begin
            d_en <= mem_rdata[EN_BIT];
            d_ll <= mem_rdata[LL_BIT];
            pend <= mem_rdata[NOPT-1:0];
            fa <= fa + STEP;
            st <= S_OPT;
          end
        S_OPT:
          if (mem_rvalid) begin
            if (pick[0]) ch_ssa   <= mem_rdata;
            if (pick[1]) ch_dsa   <= mem_rdata;
            if (pick[2]) ch_blksz <= mem_rdata;
            if (pick[3]) ch_csz   <= mem_rdata;
            pend <= pend_nx;
            fa <= fa + STEP;
          end
        S_ARM:
          if (trig_edge) begin
            cell_go <= 1'b1;
            st <= S_XFER;
          end
        S_XFER:
          if (cell_done) begin
            if (last) begin
              xcnt  <= '0;
              ch_en <= 1'b0;
              if (ch_llen) begin
                fa <= ch_nxt;
                st <= S_NXT;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              xcnt <= xsum;
              if (ch_cast) cell_go <= 1'b1;
              else st <= S_ARM;
            end
          end
        default: st <= S_IDLE;
      endcase

      if (commit) begin
        ch_nxt  <= nxt_tmp;
        ch_en   <= c_en;
        ch_llen <= c_ll;
        st      <= c_en ? S_ARM : S_IDLE;
      end
    end
  end

  AST_FETCH_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ch_en); // R4
  AST_GO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cell_go |-> ch_en); // R5
  AST_DROP_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_edge && !ch_en) |=> !cell_go); // R6
  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cell_go |=> !cell_go); // R7
  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && cell_done && last) |=> !ch_en); // R8
  AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && cell_done && last && !ch_llen) |=> !mem_req); // R9
endmodule

// File: tb/dma_chain_seq_bench.sv
module dma_chain_seq_bench;
  localparam int W = 32;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_wr = 1'b0, trig = 1'b0;
  logic [2:0] sw_sel = '0;
  logic [W-1:0] sw_wdata = '0;
  logic mem_req, mem_rvalid = 1'b0, cell_go, cell_done = 1'b0;
  logic [W-1:0] mem_addr, mem_rdata = '0;
  logic ch_en, ch_llen, ch_cast;
  logic [W-1:0] ch_nxt, ch_ssa, ch_dsa, ch_blksz, ch_csz;

  int tests = 0, fails = 0, rd_cnt = 0, go_cnt = 0, dly = 0;
  logic [W-1:0] mem [64];

  always #(TCLK/2) clk = ~clk;

  dma_chain_seq #(.W(W)) u_dma_chain_seq (
    .clk, .rst_n, .sw_wr, .sw_sel, .sw_wdata, .trig,
    .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
    .cell_go, .cell_done, .ch_en, .ch_llen, .ch_cast,
    .ch_nxt, .ch_ssa, .ch_dsa, .ch_blksz, .ch_csz
  );

  always @(posedge clk) begin
    mem_rvalid <= mem_req && !mem_rvalid;
    mem_rdata  <= mem[mem_addr[7:2]];
    if (mem_rvalid) rd_cnt <= rd_cnt + 1;
    if (cell_go) go_cnt <= go_cnt + 1;
    cell_done <= 1'b0;
    if (cell_go) dly <= 3;
    else if (dly != 0) begin
      dly <= dly - 1;
      if (dly == 1) cell_done <= 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sw(input logic [2:0] s, input logic [W-1:0] d);
    @(negedge clk); sw_wr = 1'b1; sw_sel = s; sw_wdata = d;
    @(negedge clk); sw_wr = 1'b0;
  endtask

  task automatic pulse;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_en(input logic v, input string tag);
    for (int i = 0; i < 400; i++) begin
      if (ch_en == v) return;
      @(negedge clk);
    end
    check(1'b0, tag, ch_en, v);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(ch_en == 0 && ch_llen == 0 && ch_cast == 0, "R1 ctrl bits", {ch_en, ch_llen, ch_cast}, 0);
    check(mem_req == 0 && cell_go == 0, "R1 req/go", {mem_req, cell_go}, 0);
  endtask

  task automatic t_first_load;
    int r0, g0;
    sw(3'd2, 32'hD00); sw(3'd3, 16); sw(3'd4, 4); sw(3'd1, 32'h5); sw(3'd0, 32'h0);
    r0 = rd_cnt; g0 = go_cnt;
    sw(3'd5, 32'h3);
    check(mem_req == 1 && mem_addr == 0, "R2 fetch start addr", {mem_req, mem_addr}, 0);
    check(ch_en == 0, "R4 disarmed while loading", ch_en, 0);
    pulse();
    check(mem_req == 1, "R6 trigger fired during load", mem_req, 1);
    wait_en(1'b1, "R4 arm after load");
    idle_cycles(10);
    check(go_cnt - g0 == 0, "R6 trigger during load dropped", go_cnt - g0, 0);
    check(rd_cnt - r0 == 3, "R3 word count one flag", rd_cnt - r0, 3);
    check(ch_ssa == 32'h1000, "R3 ssa flagged", ch_ssa, 32'h1000);
    check(ch_dsa == 32'hD00, "R3 dsa kept", ch_dsa, 32'hD00);
    check(ch_nxt == 32'h40 && ch_llen == 1, "R4 nxt/llen commit", ch_nxt, 32'h40);
    check(mem_req == 0, "R4 no req when armed", mem_req, 0);
  endtask

  task automatic t_cast_block;
    int g0, r0;
    g0 = go_cnt;
    pulse();
    wait_en(1'b0, "R8 enable clears");
    check(go_cnt - g0 == 4, "R7 auto-start cells", go_cnt - g0, 4);
    check(mem_req == 1 && mem_addr == 32'h40, "R8 next fetch addr", mem_addr, 32'h40);
    r0 = rd_cnt;
    wait_en(1'b1, "R8 arm second");
    check(rd_cnt - r0 == 6, "R3 word count four flags", rd_cnt - r0, 6);
    check(ch_ssa == 32'h2000 && ch_dsa == 32'h3000, "R3 ssa/dsa order", ch_dsa, 32'h3000);
    check(ch_blksz == 12 && ch_csz == 4, "R3 blk/csz order", ch_blksz, 12);
    check(ch_nxt == 0, "R4 nxt second", ch_nxt, 0);
  endtask

  task automatic t_circular;
    int g0;
    g0 = go_cnt;
    pulse();
    wait_en(1'b0, "R8 second block end");
    check(go_cnt - g0 == 3, "R7 three cells", go_cnt - g0, 3);
    check(mem_req == 1 && mem_addr == 0, "R8 circular wrap", mem_addr, 0);
    wait_en(1'b1, "R8 rearm first");
    check(ch_ssa == 32'h1000 && ch_nxt == 32'h40, "R3 reload first", ch_ssa, 32'h1000);
    check(ch_blksz == 12 && ch_dsa == 32'h3000, "R3 unflagged kept", ch_blksz, 12);
  endtask

  task automatic t_held_trigger;
    int g0;
    sw(3'd5, 32'h1);
    check(mem_req == 0 && ch_cast == 0, "R2 ctrl write while armed", mem_req, 0);
    g0 = go_cnt;
    @(negedge clk); trig = 1'b1;
    idle_cycles(30);
    check(go_cnt - g0 == 1, "R5 held trigger once", go_cnt - g0, 1);
    check(ch_en == 1, "R7 waits for trigger", ch_en, 1);
    trig = 1'b0;
    idle_cycles(2);
    pulse();
    idle_cycles(10);
    check(go_cnt - g0 == 2, "R7 second cell on trigger", go_cnt - g0, 2);
  endtask

  task automatic t_stop_midblock;
    bit seen = 0;
    sw(3'd5, 32'h0);
    pulse();
    wait_en(1'b0, "R9 block finishes");
    for (int i = 0; i < 20; i++) begin
      if (mem_req) seen = 1;
      @(negedge clk);
    end
    check(!seen, "R9 no fetch after stop", seen, 0);
    check(ch_llen == 0, "R9 llen stays clear", ch_llen, 0);
  endtask

  task automatic t_disabled_desc;
    int g0;
    sw(3'd0, 32'h80);
    sw(3'd5, 32'h1);
    check(mem_req == 1 && mem_addr == 32'h80, "R2 fetch disabled desc", mem_addr, 32'h80);
    idle_cycles(20);
    check(ch_en == 0 && mem_req == 0, "R10 stays disabled", {ch_en, mem_req}, 0);
    check(ch_llen == 1 && ch_nxt == 0, "R10 bits committed", ch_nxt, 0);
    g0 = go_cnt;
    pulse();
    idle_cycles(10);
    check(go_cnt - g0 == 0, "R10 trigger ignored", go_cnt - g0, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0] = 32'h40;  mem[1] = 32'h301; mem[2] = 32'h1000;
    mem[16] = 32'h0;  mem[17] = 32'h30F; mem[18] = 32'h2000;
    mem[19] = 32'h3000; mem[20] = 12; mem[21] = 4;
    mem[32] = 32'h0;  mem[33] = 32'h200;
    idle_cycles(3);
    rst_n = 1'b1;
    t_reset();
    t_first_load();
    t_cast_block();
    t_circular();
    t_held_trigger();
    t_stop_midblock();
    t_disabled_desc();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule